// File: doc/BRIEF.md
# Digit-Serial GF(2^m) Multiply-by-Square Pipeline

This block computes P = A·B² over the binary extension field GF(2^M). Elements use the standard polynomial basis, and products are reduced modulo a fixed irreducible polynomial x^M + T(x). The tail T is a synthesis-time parameter. Both operands arrive L bits per clock, most significant digit first. A start flag marks the first digit of each operand pair. The result leaves the block the same way, L bits per clock, with a valid flag and a first-digit flag. The result is the basic step of inversion and division by repeated squaring: chaining such units yields B^-1 and A/B.

After the last operand digit is assembled, the product is formed in a one-way systolic chain of M registered cells. The single head cell starts the partial product from the top coefficient of B. Each of the M−1 body cells multiplies the running value by x², reduces it, and conditionally adds A. The operand A and the still-unused coefficients of B travel forward alongside the partial product, so no signal flows backward. A one-bit framing marker travels down the chain with each product. A new operand pair may start every M/L cycles, so several products are in flight at once. M must be a multiple of L.

Top module: `gf_ab2_mult`

## Requirements
- R1: Each result equals A·B² mod (x^M + POLY_TAIL). Bit i of any operand or result is the coefficient of x^i.
- R2: Operands and result move L bits per clock, most significant digit first. Digit j of a word is bits [M−1−jL : M−L−jL].
- R3: A digit with both inValid and inStart high opens a frame and is the first digit of A and of B. The frame closes after D = M/L accepted digits, and that pair produces exactly one result.
- R4: Any cycle with inValid low is ignored, inStart and the digit inputs included. The digits of a frame may therefore be separated by idle cycles of any length.
- R5: A digit with inValid high and inStart low is ignored when no frame is open. This covers the time before the first frame and the time after a frame has closed.
- R6: inStart with inValid high while a frame is open drops the partial operands and opens a new frame with the current digit.
- R7: Suppose the last operand digit is accepted at rising edge n. The first result digit is then presented in the cycle that follows edge n+M.
- R8: Each result occupies D consecutive cycles with outValid high. outFirst is high on the first of those cycles only, and outFirst never appears without outValid.
- R9: Frames presented back to back, one digit per cycle, give results in input order with no idle cycle between them.
- R10: During reset and after reset with no input, outValid and outFirst are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operand digit is present this cycle |
| inStart | input | 1 | The current digit is the first of a new operand pair |
| inDigitA | input | L | Digit of multiplicand A |
| inDigitB | input | L | Digit of B, the operand that is squared |
| outValid | output | 1 | outDigit carries a result digit |
| outFirst | output | 1 | The current result digit is the most significant one |
| outDigit | output | L | Digit of the product A·B² |

## Verification
The hardest case to reach from the ports is a steady stream: one result still leaving the serializer while the next is loaded into it, and further products spread along the chain. The stimulus reaches this with runs of frames presented with no idle cycle between digits. The bench requires the first digit of each result at an exact cycle, and the checker forbids any truncated or gapped result run. Random idle gaps inside frames, stray digits outside frames, and restarts part-way through a frame test the framing rules. The field corners are zero, one, x^(M−1) and the all-ones element.

// File: rtl/gf_ab2_pkg.sv
package gf_ab2_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic capture;   // shift the current input digit into the operand assembly
    logic loadOut;   // a finished product leaves the chain; load the serializer
    logic shiftOut;  // advance the serializer by one digit
  } gfStrobes_t;

endpackage

// File: rtl/gf_ab2_cell_head.sv
// Boundary cell: starts the partial product from the top coefficient of B.
module gf_ab2_cell_head #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic [M-1:0] aIn,
  input  logic         bBit,
  output logic [M-1:0] pOut
);

  always_ff @(posedge clk) begin
    pOut <= bBit ? aIn : '0;
  end

endmodule

// File: rtl/gf_ab2_cell_body.sv
// Interior cell: p <- p*x^2 mod f + bBit*A
module gf_ab2_cell_body #(
  parameter int           M    = 8,
  parameter logic [M-1:0] TAIL = 8'h1B
) (
  input  logic         clk,
  input  logic [M-1:0] pIn,
  input  logic [M-1:0] aIn,
  input  logic         bBit,
  output logic [M-1:0] pOut
);

  function automatic logic [M-1:0] timesX(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? TAIL : '0);
  endfunction

  logic [M-1:0] shifted;
  logic [M-1:0] addend;

  always_comb begin
    shifted = timesX(timesX(pIn));
    addend  = bBit ? aIn : '0;
  end

  always_ff @(posedge clk) begin
    pOut <= shifted ^ addend;
  end

endmodule

// File: rtl/gf_ab2_ctrl.sv
// Framing, marker pipeline and serializer count.
module gf_ab2_ctrl
  import gf_ab2_pkg::*;
#(
  parameter int M = 8,
  parameter int L = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  output gfStrobes_t strb,
  output logic       outValid,
  output logic       outFirst
);

  localparam int D  = M / L;
  localparam int CW = $clog2(D + 1);

  logic          frameOpen;
  logic [CW-1:0] digCnt;
  logic [CW-1:0] nextCnt;
  logic          capture;
  logic          complete;
  logic [M-1:0]  markPipe;
  logic [CW-1:0] outCnt;

  always_comb begin
    capture  = inValid && (inStart || frameOpen);
    nextCnt  = inStart ? CW'(1) : digCnt + CW'(1);
    complete = capture && (nextCnt == CW'(D));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOpen <= 1'b0;
      digCnt    <= '0;
    end else if (capture) begin
      frameOpen <= !complete;
      digCnt    <= complete ? '0 : nextCnt;
    end
  end

  // framing marker travels with each product through the M cells
  always_ff @(posedge clk) begin
    if (!rstN) markPipe <= '0;
    else       markPipe <= {markPipe[M-2:0], complete};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                outCnt <= '0;
    else if (markPipe[M-1])   outCnt <= CW'(D);
    else if (outCnt != '0)    outCnt <= outCnt - CW'(1);
  end

  always_comb begin
    strb.capture  = capture;
    strb.loadOut  = markPipe[M-1];
    strb.shiftOut = (outCnt != '0) && !markPipe[M-1];
    outValid      = (outCnt != '0);
    outFirst      = (outCnt == CW'(D));
  end

endmodule

// File: rtl/gf_ab2_dpath.sv
// Operand assembly, systolic cell chain and result serializer.
module gf_ab2_dpath
  import gf_ab2_pkg::*;
#(
  parameter int           M    = 8,
  parameter int           L    = 2,
  parameter logic [M-1:0] TAIL = 8'h1B
) (
  input  logic         clk,
  input  gfStrobes_t   strb,
  input  logic [L-1:0] inDigitA,
  input  logic [L-1:0] inDigitB,
  output logic [L-1:0] outDigit
);

  localparam int D   = M / L;
  localparam int SH  = M - L;
  localparam int TRI = M * (M - 1) / 2;

  // offset of stage k in the triangular store of unused B coefficients
  function automatic int triOff(input int k);
    return k * (M - 1) - (k * (k - 1)) / 2;
  endfunction

  logic [M-1:0] asmA;
  logic [M-1:0] asmB;

  generate
    if (D == 1) begin : gNoAsm
      assign asmA = inDigitA;
      assign asmB = inDigitB;
    end else begin : gAsm
      logic [SH-1:0] aSh;
      logic [SH-1:0] bSh;
      assign asmA = {aSh, inDigitA};
      assign asmB = {bSh, inDigitB};
      if (D == 2) begin : gOne
        always_ff @(posedge clk) begin
          if (strb.capture) begin
            aSh <= inDigitA;
            bSh <= inDigitB;
          end
        end
      end else begin : gMany
        always_ff @(posedge clk) begin
          if (strb.capture) begin
            aSh <= {aSh[SH-L-1:0], inDigitA};
            bSh <= {bSh[SH-L-1:0], inDigitB};
          end
        end
      end
    end
  endgenerate

  logic [M-1:0]   pChain [M];
  logic [M-1:0]   aPipe  [M-1];
  logic [TRI-1:0] bTri;

  gf_ab2_cell_head #(.M(M)) u_head (
    .clk  (clk),
    .aIn  (asmA),
    .bBit (asmB[M-1]),
    .pOut (pChain[0])
  );

  generate
    for (genvar k = 0; k < M - 1; k++) begin : gPass
      if (k == 0) begin : gFirst
        always_ff @(posedge clk) begin
          aPipe[0]            <= asmA;
          bTri[0 +: M-1]      <= asmB[M-2:0];
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          aPipe[k]                    <= aPipe[k-1];
          bTri[triOff(k) +: M-1-k]    <= bTri[triOff(k-1) +: M-1-k];
        end
      end
    end

    for (genvar k = 1; k < M; k++) begin : gBody
      gf_ab2_cell_body #(.M(M), .TAIL(TAIL)) u_body (
        .clk  (clk),
        .pIn  (pChain[k-1]),
        .aIn  (aPipe[k-1]),
        .bBit (bTri[triOff(k-1) + M - 1 - k]),
        .pOut (pChain[k])
      );
    end
  endgenerate

  logic [M-1:0] oSh;

  generate
    if (D == 1) begin : gSerOne
      always_ff @(posedge clk) begin
        if (strb.loadOut) oSh <= pChain[M-1];
      end
    end else begin : gSerMany
      always_ff @(posedge clk) begin
        if (strb.loadOut)       oSh <= pChain[M-1];
        else if (strb.shiftOut) oSh <= {oSh[M-L-1:0], {L{1'b0}}};
      end
    end
  endgenerate

  assign outDigit = oSh[M-1 -: L];

endmodule

// File: rtl/gf_ab2_mult.sv
module gf_ab2_mult
  import gf_ab2_pkg::*;
#(
  parameter int           M          = 8,
  parameter int           L          = 2,
  parameter logic [M-1:0] POLY_TAIL  = 8'h1B
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inStart,
  input  logic [L-1:0] inDigitA,
  input  logic [L-1:0] inDigitB,
  output logic         outValid,
  output logic         outFirst,
  output logic [L-1:0] outDigit
);

  gfStrobes_t strb;

  gf_ab2_ctrl #(.M(M), .L(L)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inStart  (inStart),
    .strb     (strb),
    .outValid (outValid),
    .outFirst (outFirst)
  );

  gf_ab2_dpath #(.M(M), .L(L), .TAIL(POLY_TAIL)) u_dpath (
    .clk      (clk),
    .strb     (strb),
    .inDigitA (inDigitA),
    .inDigitB (inDigitB),
    .outDigit (outDigit)
  );

endmodule

// File: rtl/gf_ab2_chk.sv
module gf_ab2_chk #(
  parameter int M = 8,
  parameter int L = 2
) (
  input logic clk,
  input logic rstN,
  input logic outValid,
  input logic outFirst
);

  localparam int D  = M / L;
  localparam int CW = $clog2(D + 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         runCnt <= '0;
    else if (outFirst) runCnt <= CW'(1);
    else if (outValid) runCnt <= runCnt + CW'(1);
  end

  p_first_has_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  p_run_opens_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outFirst);

  p_run_not_long_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFirst) |-> (runCnt < CW'(D)));

  p_run_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (runCnt == CW'(D)));

  p_no_cut_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outFirst && $past(outValid)) |-> (runCnt == CW'(D)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outFirst));

endmodule

bind gf_ab2_mult gf_ab2_chk #(.M(M), .L(L)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outFirst (outFirst)
);

// File: tb/gf_ab2_mult_bench.sv
`timescale 1ns/1ps
module gf_ab2_mult_bench;

  localparam int           M    = 8;
  localparam int           L    = 2;
  localparam int           D    = M / L;
  localparam logic [M-1:0] TAIL = 8'h1B;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inStart = 1'b0;
  logic [L-1:0] inDigitA = '0;
  logic [L-1:0] inDigitB = '0;
  logic         outValid;
  logic         outFirst;
  logic [L-1:0] outDigit;

  always #4 clk = ~clk;

  gf_ab2_mult #(.M(M), .L(L), .POLY_TAIL(TAIL)) u_gf_ab2_mult (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inDigitA(inDigitA), .inDigitB(inDigitB),
    .outValid(outValid), .outFirst(outFirst), .outDigit(outDigit)
  );

  int edgeCnt = 0;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic [M-1:0] expQ[$];
  int expEdge[$];
  int digIdx = 0;
  int resultsSeen = 0;
  int expectedTotal = 0;

  function automatic logic [M-1:0] refTimesX(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? TAIL : '0);
  endfunction

  function automatic logic [M-1:0] refMul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] acc = '0;
    logic [M-1:0] sh = a;
    for (int i = 0; i < M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = refTimesX(sh);
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] refAb2(input logic [M-1:0] a, input logic [M-1:0] b);
    return refMul(a, refMul(b, b));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", tag, act, exp, edgeCnt);
    end
  endtask

  // result monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 R6 unexpected result digit", {30'd0, outDigit}, 32'd0);
        end else begin
          logic [M-1:0] w;
          logic [L-1:0] expDig;
          w = expQ[0];
          expDig = w[M-1-digIdx*L -: L];
          if (digIdx == 0) begin
            check(outFirst == 1'b1, "R8 first flag on leading digit", {31'd0, outFirst}, 32'd1);
            check(edgeCnt == expEdge[0], "R7 R9 first digit timing", edgeCnt, expEdge[0]);
          end else begin
            check(outFirst == 1'b0, "R8 first flag on later digit", {31'd0, outFirst}, 32'd0);
          end
          check(outDigit == expDig, "R1 R2 result digit", {30'd0, outDigit}, {30'd0, expDig});
          digIdx++;
          if (digIdx == D) begin
            digIdx = 0;
            void'(expQ.pop_front());
            void'(expEdge.pop_front());
            resultsSeen++;
          end
        end
      end else if (digIdx != 0) begin
        check(1'b0, "R8 gap inside result", 32'd0, 32'd1);
        digIdx = 0;
      end
    end
  end

  task automatic idleJunk(input int n);
    for (int i = 0; i < n; i++) begin
      inValid  = 1'b0;
      inStart  = 1'($urandom);
      inDigitA = L'($urandom);
      inDigitB = L'($urandom);
      @(negedge clk);
    end
    inStart = 1'b0;
  endtask

  task automatic sendDigit(input bit st, input logic [L-1:0] a, input logic [L-1:0] b);
    inValid  = 1'b1;
    inStart  = st;
    inDigitA = a;
    inDigitB = b;
    @(negedge clk);
    inValid  = 1'b0;
    inStart  = 1'($urandom);
    inDigitA = L'($urandom);
    inDigitB = L'($urandom);
  endtask

  task automatic sendFrame(input logic [M-1:0] a, input logic [M-1:0] b, input int gapMax);
    for (int i = 0; i < D; i++) begin
      if (gapMax > 0 && i > 0) idleJunk($urandom % (gapMax + 1));
      sendDigit(i == 0, a[M-1-i*L -: L], b[M-1-i*L -: L]);
    end
    expQ.push_back(refAb2(a, b));
    expEdge.push_back(edgeCnt + M);
    expectedTotal++;
    inStart = 1'b0;
  endtask

  task automatic drainAndCount(input string tag);
    idleJunk(M + 2 * D + 3);
    check(resultsSeen == expectedTotal, tag, resultsSeen, expectedTotal);
    check(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] ones;
    ones = '1;
    void'($urandom(32'd20240917));
    rstN = 1'b0;
    @(negedge clk);
    idleJunk(2);
    check(outValid == 1'b0, "R10 outValid in reset", {31'd0, outValid}, 32'd0);
    check(outFirst == 1'b0, "R10 outFirst in reset", {31'd0, outFirst}, 32'd0);
    rstN = 1'b1;
    idleJunk(M + 3);
    check(outValid == 1'b0, "R10 outValid idle after reset", {31'd0, outValid}, 32'd0);

    // directed field corners (R1, R3)
    sendFrame('0, 8'hA5, 0);            idleJunk(2);
    sendFrame(8'h3C, '0, 0);            idleJunk(2);
    sendFrame(8'h01, 8'h01, 0);         idleJunk(1);
    sendFrame(ones, ones, 0);           idleJunk(1);
    sendFrame(8'h01, 8'h80, 0);         idleJunk(1);
    sendFrame(ones, 8'h01, 0);
    drainAndCount("R3 one result per frame (directed)");

    // idle cycles inside frames (R4)
    for (int i = 0; i < 25; i++) begin
      sendFrame(M'($urandom), M'($urandom), 3);
      idleJunk($urandom % 3);
    end
    drainAndCount("R4 frames with idle gaps");

    // stray digits outside a frame (R5)
    for (int i = 0; i < 3; i++) sendDigit(1'b0, L'($urandom), L'($urandom));
    sendFrame(8'h57, 8'h83, 0);
    for (int i = 0; i < 4; i++) sendDigit(1'b0, L'($urandom), L'($urandom));
    sendFrame(8'hC1, 8'h2E, 1);
    drainAndCount("R5 stray digits ignored");

    // restart within an open frame (R6)
    sendDigit(1'b1, L'($urandom), L'($urandom));
    sendDigit(1'b0, L'($urandom), L'($urandom));
    sendFrame(8'h9D, 8'h46, 0);
    for (int i = 0; i < D - 1; i++) sendDigit(i == 0, L'($urandom), L'($urandom));
    sendFrame(M'($urandom), M'($urandom), 2);
    drainAndCount("R6 restart drops partial frame");

    // back-to-back streaming (R9)
    for (int i = 0; i < 40; i++) sendFrame(M'($urandom), M'($urandom), 0);
    drainAndCount("R9 back-to-back results in order");

    // mixed random traffic
    for (int i = 0; i < 40; i++) begin
      sendFrame(M'($urandom), M'($urandom), $urandom % 3);
      if ($urandom % 4 == 0) idleJunk($urandom % 5);
    end
    drainAndCount("R1 R7 mixed traffic");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule